// File: doc/BRIEF.md
# Shared-Memory Line Requester

This block sits between a processor's cache and a shared bus. The bus leads to one slow memory that serves several processors. When the cache misses, the cache hands over a word address, a direction and, for a store, one data word. The agent then requests the bus. In the cycle the bus is granted, the agent looks at the memory's state code. If the memory is occupied, or is presenting someone else's result, the agent lets the bus go for one cycle and then asks again. If the memory is free, the agent fires a one-cycle read or write strobe with the address. For a store, the agent also places the data word in its slot of the line.

The memory finishes in a later bus tenure of its own. It shows the done code together with an address and a whole line. The agent takes that line only when the returned address falls inside the line it is waiting for. It then gives the cache a one-cycle completion pulse with the line and goes back to idle. Each line holds two 8-bit words. The memory has ten words, and a read takes two cycles and a write three, so the agent has to wait for several cycles.

Top module: `busReqAgent`

## Requirements
- R1: A synchronous active-high reset leaves busReq, rdStrobe, wrStrobe, doneValid and agentBusy low, and drops any pending transaction.
- R2: missValid is taken only while the agent is idle. On the next cycle busReq and agentBusy are high. A missValid that arrives while agentBusy is high has no effect: the pending address and data are kept, and the agent returns to idle after the one completion.
- R3: When busGrant is seen while memState is busy (code 0), no strobe is issued. busReq is low in the following cycle and high again in the cycle after that.
- R4: When busGrant is seen while memState is free (code 1), exactly one strobe fires in that same cycle: rdStrobe for a load, wrStrobe for a store. busAddrOut then equals the miss address. busReq and both strobes are low in the next cycle.
- R5: For a store, busDataOut carries the write word in slot (address mod 2), with slot k at bits [8k+7:8k]. The other slot is zero.
- R6: Any memState code other than free (code 1) at grant time is handled like busy. This includes done (code 2) and the unused codes.
- R7: The returned line is captured only in a cycle where memState is done (code 2) and busAddrIn divided by 2 equals the pending address divided by 2. The agent ignores a done with any other line address, and it ignores any line shown while the memory is not done.
- R8: The cycle after the capture, doneValid is high for exactly one cycle. doneLine then holds the captured bus line, with word k at bits [8k+7:8k]. After that the agent is idle with busReq low.
- R9: While busReq is high and busGrant is low, busReq stays high and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| missValid | input | 1 | Cache starts a line transaction (one cycle) |
| missWrite | input | 1 | 1 = store, 0 = load |
| missAddr | input | 4 | Word address of the miss |
| missData | input | 8 | Word to store |
| agentBusy | output | 1 | A transaction is in progress |
| busReq | output | 1 | Bus request to the arbiter |
| busGrant | input | 1 | Bus grant from the arbiter |
| memState | input | 3 | Memory state: 0 busy, 1 free, 2 done |
| rdStrobe | output | 1 | Read command to memory |
| wrStrobe | output | 1 | Write command to memory |
| busAddrOut | output | 4 | Address driven with a command |
| busDataOut | output | 16 | Line driven with a write command |
| busAddrIn | input | 4 | Address shown by memory when done |
| busLineIn | input | 16 | Line shown by memory when done |
| doneValid | output | 1 | One-cycle completion pulse to the cache |
| doneLine | output | 16 | Captured line |

## Verification
The bench builds the agent with its defaults: 8-bit words, two-word lines and 4-bit addresses. This covers the whole ten-word memory and both slot positions of a store. With two-word lines, the bench can hand back the neighbour word's address and still expect a capture. It can also use an address one line over as a decoy that must be refused. Busy-retry runs use codes 0, 2 and 5, and wait latencies of two and three cycles match the memory's read and write timing.

// File: rtl/busAgentPkg.sv
package busAgentPkg;
  localparam int MEM_STATE_W = 3;
  localparam logic [MEM_STATE_W-1:0] MEM_BUSY = 3'd0;
  localparam logic [MEM_STATE_W-1:0] MEM_FREE = 3'd1;
  localparam logic [MEM_STATE_W-1:0] MEM_DONE = 3'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_BACKOFF,
    ST_WAIT,
    ST_DONE
  } agentState_e;

  typedef struct packed {
    logic loadMiss;
    logic capture;
  } dpStrobes_t;
endpackage

// File: rtl/agentCtrl.sv
module agentCtrl
  import busAgentPkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   missValid,
  input  logic                   busGrant,
  input  logic [MEM_STATE_W-1:0] memState,
  input  logic                   lineMatch,
  input  logic                   pendWrite,
  output logic                   busReq,
  output logic                   rdStrobe,
  output logic                   wrStrobe,
  output logic                   doneValid,
  output logic                   agentBusy,
  output dpStrobes_t             strobes
);
  agentState_e state, stateNext;
  logic issue;

  assign issue = (state == ST_REQ) && busGrant && (memState == MEM_FREE);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (missValid) stateNext = ST_REQ;
      ST_REQ:     if (busGrant) stateNext = (memState == MEM_FREE) ? ST_WAIT : ST_BACKOFF;
      ST_BACKOFF: stateNext = ST_REQ;
      ST_WAIT:    if (memState == MEM_DONE && lineMatch) stateNext = ST_DONE;
      ST_DONE:    stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign busReq           = (state == ST_REQ);
  assign rdStrobe         = issue && !pendWrite;
  assign wrStrobe         = issue && pendWrite;
  assign doneValid        = (state == ST_DONE);
  assign agentBusy        = (state != ST_IDLE);
  assign strobes.loadMiss = (state == ST_IDLE) && missValid;
  assign strobes.capture  = (state == ST_WAIT) && (memState == MEM_DONE) && lineMatch;

  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busReq && busGrant && memState != MEM_FREE) |=> !busReq); // R3
  AST_BUSY_REREQ: assert property (@(posedge clk) disable iff (rst)
    (busReq && busGrant && memState != MEM_FREE) |=> ##1 busReq); // R6
  AST_ISSUE_DROPS: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe || wrStrobe) |=> (!busReq && !rdStrobe && !wrStrobe)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    doneValid |=> (!doneValid && !agentBusy)); // R8
  AST_NO_GRANT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busReq && !busGrant) |=> busReq); // R9
endmodule

// File: rtl/agentDatapath.sv
module agentDatapath
  import busAgentPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LINE_WORDS = 2,
  parameter int ADDR_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  dpStrobes_t                   strobes,
  input  logic                         missWrite,
  input  logic [ADDR_W-1:0]            missAddr,
  input  logic [DATA_W-1:0]            missData,
  input  logic [ADDR_W-1:0]            busAddrIn,
  input  logic [DATA_W*LINE_WORDS-1:0] busLineIn,
  output logic                         pendWrite,
  output logic                         lineMatch,
  output logic [ADDR_W-1:0]            busAddrOut,
  output logic [DATA_W*LINE_WORDS-1:0] busDataOut,
  output logic [DATA_W*LINE_WORDS-1:0] doneLine
);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int LINE_W = DATA_W * LINE_WORDS;

  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendData;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendAddr  <= '0;
      pendData  <= '0;
      pendWrite <= 1'b0;
    end else if (strobes.loadMiss) begin
      pendAddr  <= missAddr;
      pendData  <= missData;
      pendWrite <= missWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  doneLine <= '0;
    else if (strobes.capture) doneLine <= busLineIn;
  end

  assign lineMatch  = (busAddrIn >> OFF_W) == (pendAddr >> OFF_W);
  assign busAddrOut = pendAddr;

  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_slot
    assign busDataOut[k*DATA_W +: DATA_W] =
      (pendAddr[OFF_W-1:0] == OFF_W'(k)) ? pendData : '0;
  end

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!strobes.capture && !strobes.loadMiss) |=> $stable(doneLine)); // R8
  AST_SLOT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $countones(busDataOut) <= $countones(pendData)); // R5

  logic unusedLine;
  assign unusedLine = ^LINE_W;
endmodule

// File: rtl/busReqAgent.sv
module busReqAgent
  import busAgentPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LINE_WORDS = 2,
  parameter int ADDR_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         missValid,
  input  logic                         missWrite,
  input  logic [ADDR_W-1:0]            missAddr,
  input  logic [DATA_W-1:0]            missData,
  output logic                         agentBusy,
  output logic                         busReq,
  input  logic                         busGrant,
  input  logic [2:0]                   memState,
  output logic                         rdStrobe,
  output logic                         wrStrobe,
  output logic [ADDR_W-1:0]            busAddrOut,
  output logic [DATA_W*LINE_WORDS-1:0] busDataOut,
  input  logic [ADDR_W-1:0]            busAddrIn,
  input  logic [DATA_W*LINE_WORDS-1:0] busLineIn,
  output logic                         doneValid,
  output logic [DATA_W*LINE_WORDS-1:0] doneLine
);
  dpStrobes_t strobes;
  logic pendWrite;
  logic lineMatch;

  agentCtrl u_ctrl (
    .clk(clk), .rst(rst), .missValid(missValid), .busGrant(busGrant),
    .memState(memState), .lineMatch(lineMatch), .pendWrite(pendWrite),
    .busReq(busReq), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .doneValid(doneValid), .agentBusy(agentBusy), .strobes(strobes)
  );

  agentDatapath #(.DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .missWrite(missWrite),
    .missAddr(missAddr), .missData(missData), .busAddrIn(busAddrIn),
    .busLineIn(busLineIn), .pendWrite(pendWrite), .lineMatch(lineMatch),
    .busAddrOut(busAddrOut), .busDataOut(busDataOut), .doneLine(doneLine)
  );

  AST_LINE_CAPTURED: assert property (@(posedge clk) disable iff (rst)
    doneValid |-> (doneLine == $past(busLineIn) && $past(memState) == MEM_DONE)); // R7
endmodule

// File: tb/busReqAgent_tb.sv
module busReqAgent_tb;
  logic clk = 1'b0;
  logic rst;
  logic missValid, missWrite;
  logic [3:0] missAddr;
  logic [7:0] missData;
  logic agentBusy, busReq, busGrant, rdStrobe, wrStrobe, doneValid;
  logic [2:0] memState;
  logic [3:0] busAddrOut, busAddrIn;
  logic [15:0] busDataOut, busLineIn, doneLine;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [10];
  logic [15:0] expQ [$];

  always #4 clk = ~clk;

  busReqAgent u_dut (
    .clk(clk), .rst(rst), .missValid(missValid), .missWrite(missWrite),
    .missAddr(missAddr), .missData(missData), .agentBusy(agentBusy),
    .busReq(busReq), .busGrant(busGrant), .memState(memState),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .busAddrOut(busAddrOut),
    .busDataOut(busDataOut), .busAddrIn(busAddrIn), .busLineIn(busLineIn),
    .doneValid(doneValid), .doneLine(doneLine)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected line whenever a completion is seen (R8)
  always @(negedge clk) begin
    if (!rst && doneValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R8: actual=%h expected=<none queued>", doneLine);
      end else begin
        logic [15:0] e;
        e = expQ.pop_front();
        if (doneLine !== e) begin
          errors++;
          $display("FAIL R8: actual=%h expected=%h", doneLine, e);
        end
      end
    end
  end

  task automatic runTxn(input bit wr, input logic [3:0] a, input logic [7:0] d,
                        input int retries, input logic [2:0] retryCode,
                        input int lat, input bit decoy, input bit probeMiss);
    logic [3:0] base;
    logic [15:0] expLine;
    @(negedge clk);
    missValid = 1'b1; missWrite = wr; missAddr = a; missData = d;
    @(negedge clk);
    missValid = 1'b0;
    chk("R2 busReq after miss", busReq, 1);
    chk("R2 agentBusy after miss", agentBusy, 1);
    @(negedge clk);
    chk("R9 busReq held without grant", busReq, 1);
    chk("R9 no strobe without grant", {rdStrobe, wrStrobe}, 0);
    for (int i = 0; i < retries; i++) begin
      busGrant = 1'b1; memState = retryCode;
      #1 chk((retryCode == 3'd0) ? "R3 no strobe busy" : "R6 no strobe non-free", {rdStrobe, wrStrobe}, 0);
      @(negedge clk);
      busGrant = 1'b0; memState = 3'd0;
      chk("R3 bus released", busReq, 0);
      @(negedge clk);
      chk("R3 bus re-requested", busReq, 1);
    end
    busGrant = 1'b1; memState = 3'd1;
    if (wr) model[a] = d;
    base = {a[3:1], 1'b0};
    expLine = {model[base + 1], model[base]};
    #1;
    chk("R4 strobe kind", {rdStrobe, wrStrobe}, wr ? 2'b01 : 2'b10);
    chk("R4 address out", busAddrOut, a);
    if (wr) chk("R5 store slot", busDataOut, a[0] ? {d, 8'h00} : {8'h00, d});
    @(negedge clk);
    busGrant = 1'b0; memState = 3'd0;
    chk("R4 request dropped after issue", busReq, 0);
    chk("R4 strobe single cycle", {rdStrobe, wrStrobe}, 0);
    busAddrIn = a; busLineIn = 16'hBEEF;
    if (probeMiss) begin
      missValid = 1'b1; missAddr = a ^ 4'd2; missData = 8'h77; missWrite = ~wr;
    end
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      missValid = 1'b0;
      chk("R7 no capture while busy", doneValid, 0);
    end
    if (decoy) begin
      memState = 3'd2; busAddrIn = a ^ 4'd2; busLineIn = 16'hDEAD;
      @(negedge clk);
      memState = 3'd0;
      chk("R7 foreign line refused", doneValid, 0);
      @(negedge clk);
      chk("R7 still waiting", agentBusy, 1);
    end
    memState = 3'd2; busAddrIn = a ^ 4'd1; busLineIn = expLine;
    expQ.push_back(expLine);
    @(negedge clk);
    memState = 3'd1; busLineIn = 16'h0;
    chk("R8 completion pulse", doneValid, 1);
    chk("R8 captured line", doneLine, expLine);
    @(negedge clk);
    memState = 3'd0;
    chk("R8 pulse ends", doneValid, 0);
    chk("R2 idle after one completion", agentBusy, 0);
    chk("R2 no request from ignored miss", busReq, 0);
  endtask

  initial begin
    for (int i = 0; i < 10; i++) model[i] = 8'(i * 17 + 3);
    rst = 1'b1; missValid = 1'b0; missWrite = 1'b0; missAddr = '0; missData = '0;
    busGrant = 1'b0; memState = 3'd0; busAddrIn = '0; busLineIn = '0;
    repeat (3) @(negedge clk);
    chk("R1 busReq reset", busReq, 0);
    chk("R1 strobes reset", {rdStrobe, wrStrobe}, 0);
    chk("R1 doneValid reset", doneValid, 0);
    chk("R1 agentBusy reset", agentBusy, 0);
    rst = 1'b0;
    runTxn(1'b0, 4'd3, 8'h00, 0, 3'd0, 2, 1'b0, 1'b0);
    runTxn(1'b1, 4'd4, 8'hA5, 2, 3'd0, 3, 1'b0, 1'b0);
    runTxn(1'b0, 4'd4, 8'h00, 1, 3'd2, 2, 1'b1, 1'b0);
    runTxn(1'b1, 4'd9, 8'h3C, 1, 3'd5, 3, 1'b0, 1'b1);
    runTxn(1'b0, 4'd8, 8'h00, 0, 3'd0, 2, 1'b1, 1'b1);
    // R1: reset in mid-transaction clears the pending work
    @(negedge clk);
    missValid = 1'b1; missAddr = 4'd1;
    @(negedge clk);
    missValid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset clears pending", {busReq, agentBusy}, 0);
    @(negedge clk);
    chk("R1 stays idle after reset", busReq, 0);
    chk("R8 queue drained", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule